// File: doc/BRIEF.md
# Fault-Detecting Tower-Field Byte Substitution Unit

This block computes the AES SubBytes substitution of one byte. It does not use a lookup table. The byte is carried into the composite field GF(((2^2)^2)^2). The multiplicative inverse is formed there, and the result is carried back through a linear map that also applies the AES affine step. The arithmetic runs as a cascade of five stages:

1. Forward basis change.
2. Norm computation in GF(2^4).
3. GF(2^4) inversion.
4. Back-multiplication.
5. Reverse basis change merged with the affine step.

Each stage has two parity units:

- A prediction unit, which derives the expected parity of the stage result from the stage's inputs.
- A calculation unit, which takes the parity of the stage result that was actually produced.

Any disagreement in any stage raises an error flag in the same cycle as the output byte it concerns. Because of this, a single flipped bit anywhere along the cascade is caught, even where it would later spread into an even number of wrong output bits.

For test, a fault mask is XOR-ed onto every stage result. When the mask is zero, the block behaves as a plain substitution unit. By default, the substituted byte and the flag are registered. A parameter can remove that register.

Top module: `tower_sbox_guarded`

## Requirements
- R1: While reset (active low) is held, and in the first cycle after it, the output byte is 0x00 and the error flag is 0.
- R2: With the fault mask at zero, the output equals the AES S-box value of the input byte, for every one of the 256 inputs.
- R3: Input 0x00 yields 0x63, with the inverse of zero taken as zero, and the error flag stays at 0.
- R4: With the fault mask at zero, the error flag is 0 for every input.
- R5: The fault mask is 48 bits wide, laid out as follows:
  - bits [7:0]: basis change stage
  - bits [19:8]: norm stage (norm, high half, low half)
  - bits [31:20]: inversion stage (inverse, high half, low half)
  - bits [39:32]: back-multiply stage
  - bits [47:40]: final stage

  Setting any single bit of the mask raises the error flag for every input.
- R6: With the default registered output, a new input appears on the output and flag one clock edge after it is applied, and not before.
- R7: A single mask bit k in the final-stage field flips exactly output bit k relative to the correct S-box value, and that same output cycle shows the flag at 1.
- R8: The flag is the OR of all five stage checks. Single bits set in two different stages together raise the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 8 | Byte to substitute |
| faultMask | input | 48 | Test fault mask, XOR-ed onto the stage results |
| subOut | output | 8 | Substituted byte |
| errFlag | output | 1 | Parity mismatch detected in at least one stage |

## Verification
The corrupted output byte and the alarm appear in the same cycle. A final-stage fault must therefore show a wrong byte and a raised flag on the same clock, not one after the other. The bench provokes this by injecting each final-stage bit with every input. It then compares, on that one sample, the byte against the reference S-box value XOR the mask, and the flag against 1. Faults in earlier stages are also swept over all inputs: each bit position is set alone, and one case sets bits in two stages at once. In every such case the flag must be raised on the same cycle as the output that the fault disturbs.

// File: rtl/tower_sbox_pkg.sv
package tower_sbox_pkg;

  localparam int S1W = 8;
  localparam int S2W = 12;
  localparam int S3W = 12;
  localparam int S4W = 8;
  localparam int S5W = 8;
  localparam int NSTAGE = 5;
  localparam int S1OFF = 0;
  localparam int S2OFF = S1OFF + S1W;
  localparam int S3OFF = S2OFF + S2W;
  localparam int S4OFF = S3OFF + S3W;
  localparam int S5OFF = S4OFF + S4W;
  localparam int MASKW = S5OFF + S5W;
  localparam logic [7:0] AFFINE_C = 8'h63;

  typedef struct packed {
    logic [NSTAGE-1:0] predicted;
    logic [NSTAGE-1:0] actual;
  } stageChk_t;

  // GF(4), polynomial basis, x^2 = x + 1
  function automatic logic [1:0] gf4Mul(input logic [1:0] a, input logic [1:0] b);
    logic t;
    t = a[1] & b[1];
    return {t ^ (a[1] & b[0]) ^ (a[0] & b[1]), t ^ (a[0] & b[0])};
  endfunction

  // GF(16) over GF(4), y^2 = y + phi
  function automatic logic [3:0] gf16Mul(input logic [3:0] a, input logic [3:0] b,
                                         input logic [1:0] phi);
    logic [1:0] hh;
    hh = gf4Mul(a[3:2], b[3:2]);
    return {hh ^ gf4Mul(a[3:2], b[1:0]) ^ gf4Mul(a[1:0], b[3:2]),
            gf4Mul(hh, phi) ^ gf4Mul(a[1:0], b[1:0])};
  endfunction

  // GF(256) over GF(16), z^2 = z + lambda
  function automatic logic [7:0] gf256Mul(input logic [7:0] a, input logic [7:0] b,
                                          input logic [3:0] lam, input logic [1:0] phi);
    logic [3:0] hh;
    hh = gf16Mul(a[7:4], b[7:4], phi);
    return {hh ^ gf16Mul(a[7:4], b[3:0], phi) ^ gf16Mul(a[3:0], b[7:4], phi),
            gf16Mul(hh, lam, phi) ^ gf16Mul(a[3:0], b[3:0], phi)};
  endfunction

  // inverse through the GF(4) norm; zero maps to zero
  function automatic logic [3:0] gf16Inv(input logic [3:0] d, input logic [1:0] phi);
    logic [1:0] nrm, ni;
    nrm = gf4Mul(gf4Mul(d[3:2], d[3:2]), phi) ^ gf4Mul(d[3:2], d[1:0]) ^ gf4Mul(d[1:0], d[1:0]);
    ni  = gf4Mul(nrm, nrm);
    return {gf4Mul(d[3:2], ni), gf4Mul(d[3:2] ^ d[1:0], ni)};
  endfunction

  // d^14, used as an independent route to the inverse
  function automatic logic [3:0] gf16Pow14(input logic [3:0] d, input logic [1:0] phi);
    logic [3:0] p2, p4, p8;
    p2 = gf16Mul(d, d, phi);
    p4 = gf16Mul(p2, p2, phi);
    p8 = gf16Mul(p4, p4, phi);
    return gf16Mul(gf16Mul(p2, p4, phi), p8, phi);
  endfunction

  function automatic logic [1:0] findPhi();
    for (int p = 3; p >= 1; p--) begin
      logic hit;
      hit = 1'b0;
      for (int y = 0; y < 4; y++)
        if ((gf4Mul(2'(y), 2'(y)) ^ 2'(y)) == 2'(p)) hit = 1'b1;
      if (!hit) return 2'(p);
    end
    return 2'd2;
  endfunction

  function automatic logic [3:0] findLambda(input logic [1:0] phi);
    for (int l = 15; l >= 1; l--) begin
      logic hit;
      hit = 1'b0;
      for (int y = 0; y < 16; y++)
        if ((gf16Mul(4'(y), 4'(y), phi) ^ 4'(y)) == 4'(l)) hit = 1'b1;
      if (!hit) return 4'(l);
    end
    return 4'd12;
  endfunction

  // an element of the tower field that is a root of x^8+x^4+x^3+x+1
  function automatic logic [7:0] findRoot(input logic [3:0] lam, input logic [1:0] phi);
    for (int g = 2; g < 256; g++) begin
      logic [7:0] pw, acc;
      pw  = 8'd1;
      acc = 8'd0;
      for (int k = 0; k <= 8; k++) begin
        if (k == 0 || k == 1 || k == 3 || k == 4 || k == 8) acc ^= pw;
        pw = gf256Mul(pw, 8'(g), lam, phi);
      end
      if (acc == 8'd0) return 8'(g);
    end
    return 8'd0;
  endfunction

  function automatic logic [7:0] matVec(input logic [63:0] cols, input logic [7:0] v);
    logic [7:0] r;
    r = 8'd0;
    for (int j = 0; j < 8; j++)
      if (v[j]) r ^= cols[8*j +: 8];
    return r;
  endfunction

  function automatic logic [63:0] buildFwd(input logic [7:0] g, input logic [3:0] lam,
                                           input logic [1:0] phi);
    logic [63:0] c;
    logic [7:0] pw;
    pw = 8'd1;
    for (int i = 0; i < 8; i++) begin
      c[8*i +: 8] = pw;
      pw = gf256Mul(pw, g, lam, phi);
    end
    return c;
  endfunction

  function automatic logic [7:0] affineLin(input logic [7:0] b);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]};
  endfunction

  // reverse basis change folded with the linear part of the affine step
  function automatic logic [63:0] buildBack(input logic [63:0] fwd);
    logic [63:0] c;
    c = 64'd0;
    for (int j = 0; j < 8; j++)
      for (int b = 0; b < 256; b++)
        if (matVec(fwd, 8'(b)) == (8'd1 << j)) c[8*j +: 8] = affineLin(8'(b));
    return c;
  endfunction

  function automatic logic [7:0] colParity(input logic [63:0] cols);
    logic [7:0] m;
    for (int j = 0; j < 8; j++) m[j] = ^cols[8*j +: 8];
    return m;
  endfunction

  localparam logic [1:0]  PHI      = findPhi();
  localparam logic [3:0]  LAMBDA   = findLambda(PHI);
  localparam logic [7:0]  ROOT     = findRoot(LAMBDA, PHI);
  localparam logic [63:0] FWD_COLS = buildFwd(ROOT, LAMBDA, PHI);
  localparam logic [63:0] BCK_COLS = buildBack(FWD_COLS);
  localparam logic [7:0]  FWD_PAR  = colParity(FWD_COLS);
  localparam logic [7:0]  BCK_PAR  = colParity(BCK_COLS);

endpackage

// File: rtl/tower_sbox_path.sv
module tower_sbox_path
  import tower_sbox_pkg::*;
(
  input  logic [7:0]       dataIn,
  input  logic [MASKW-1:0] faultMask,
  output logic [7:0]       subComb,
  output stageChk_t        stageChk
);

  logic [S1W-1:0] s1;
  logic [S2W-1:0] s2;
  logic [S3W-1:0] s3;
  logic [S4W-1:0] s4;
  logic [S5W-1:0] s5;
  logic [3:0] ah1, al1, nrm, inv3, ah3, al3;

  // stage 1: forward basis change
  always_comb begin
    s1  = matVec(FWD_COLS, dataIn) ^ faultMask[S1OFF +: S1W];
    ah1 = s1[7:4];
    al1 = s1[3:0];
  end

  // stage 2: norm, halves forwarded
  always_comb begin
    nrm = gf16Mul(gf16Mul(ah1, ah1, PHI), LAMBDA, PHI) ^ gf16Mul(ah1 ^ al1, al1, PHI);
    s2  = {nrm, ah1, al1} ^ faultMask[S2OFF +: S2W];
  end

  // stage 3: GF(16) inversion, halves forwarded
  always_comb begin
    inv3 = gf16Inv(s2[11:8], PHI);
    s3   = {inv3, s2[7:0]} ^ faultMask[S3OFF +: S3W];
    ah3  = s3[7:4];
    al3  = s3[3:0];
  end

  // stage 4: back-multiply
  always_comb
    s4 = {gf16Mul(ah3, s3[11:8], PHI), gf16Mul(ah3 ^ al3, s3[11:8], PHI)}
         ^ faultMask[S4OFF +: S4W];

  // stage 5: reverse basis change with affine step
  always_comb
    s5 = matVec(BCK_COLS, s4) ^ AFFINE_C ^ faultMask[S5OFF +: S5W];

  assign subComb = s5;

  // prediction units: parity from each stage's inputs by a separate route
  always_comb begin
    stageChk.predicted[0] = ^(dataIn & FWD_PAR);
    stageChk.predicted[1] = ^(gf16Mul(LAMBDA, gf16Mul(ah1, ah1, PHI), PHI)
                              ^ gf16Mul(ah1, al1, PHI) ^ gf16Mul(al1, al1, PHI)) ^ (^s1);
    stageChk.predicted[2] = ^gf16Pow14(s2[11:8], PHI) ^ (^s2[7:0]);
    stageChk.predicted[3] = ^gf16Mul(al3, s3[11:8], PHI);
    stageChk.predicted[4] = ^(s4 & BCK_PAR) ^ (^AFFINE_C);
  end

  // calculation units: parity over each stage's result
  always_comb begin
    stageChk.actual[0] = ^s1;
    stageChk.actual[1] = ^s2;
    stageChk.actual[2] = ^s3;
    stageChk.actual[3] = ^s4;
    stageChk.actual[4] = ^s5;
  end

endmodule

// File: rtl/tower_sbox_guard.sv
module tower_sbox_guard
  import tower_sbox_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] subComb,
  input  stageChk_t  stageChk,
  output logic [7:0] subOut,
  output logic       errFlag
);

  logic alarm;

  assign alarm = |(stageChk.predicted ^ stageChk.actual);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          subOut  <= 8'h00;
          errFlag <= 1'b0;
        end else begin
          subOut  <= subComb;
          errFlag <= alarm;
        end
      end
    end else begin : g_comb
      assign subOut  = subComb;
      assign errFlag = alarm;
    end
  endgenerate

endmodule

// File: rtl/tower_sbox_guarded.sv
module tower_sbox_guarded
  import tower_sbox_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       dataIn,
  input  logic [MASKW-1:0] faultMask,
  output logic [7:0]       subOut,
  output logic             errFlag
);

  logic [7:0] subComb;
  stageChk_t  stageChk;

  tower_sbox_path i_path (
    .dataIn    (dataIn),
    .faultMask (faultMask),
    .subComb   (subComb),
    .stageChk  (stageChk)
  );

  tower_sbox_guard #(.REG_OUT(REG_OUT)) i_guard (
    .clk      (clk),
    .rstN     (rstN),
    .subComb  (subComb),
    .stageChk (stageChk),
    .subOut   (subOut),
    .errFlag  (errFlag)
  );

endmodule

// File: rtl/tower_sbox_chk.sv
module tower_sbox_chk
  import tower_sbox_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic [7:0]       dataIn,
  input logic [MASKW-1:0] faultMask,
  input logic [7:0]       subOut,
  input logic             errFlag,
  input stageChk_t        stageChk
);

  generate
    if (REG_OUT) begin : g_seq
      // R4
      no_false_alarm_chk: assert property (@(posedge clk) disable iff (!rstN)
        (faultMask == '0) |=> !errFlag);

      // R5
      single_fault_caught_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($countones(faultMask) == 1) |=> errFlag);

      // R3
      zero_maps_chk: assert property (@(posedge clk) disable iff (!rstN)
        (dataIn == 8'h00 && faultMask == '0) |=> (subOut == 8'h63 && !errFlag));

      // R8
      stage_or_chk: assert property (@(posedge clk) disable iff (!rstN)
        (stageChk.predicted != stageChk.actual) |=> errFlag);

      // R7
      final_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($countones(faultMask[S5OFF +: S5W]) == 1 && faultMask[S5OFF-1:0] == '0)
        |=> errFlag);
    end
  endgenerate

endmodule

bind tower_sbox_guarded tower_sbox_chk #(.REG_OUT(REG_OUT)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dataIn    (dataIn),
  .faultMask (faultMask),
  .subOut    (subOut),
  .errFlag   (errFlag),
  .stageChk  (stageChk)
);

// File: tb/test_tower_sbox_guarded.sv
`timescale 1ns/1ps
module test_tower_sbox_guarded;

  localparam int MW = 48;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    dataIn = 8'h00;
  logic [MW-1:0] faultMask = '0;
  logic [7:0]    subOut;
  logic          errFlag;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tower_sbox_guarded i_tower_sbox_guarded (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .faultMask(faultMask),
    .subOut(subOut), .errFlag(errFlag)
  );

  // behavioural reference: AES field arithmetic, brute-force inverse, affine step
  function automatic int aesMul(input int a, input int b);
    int r = 0;
    for (int i = 0; i < 8; i++) begin
      if (b & 1) r ^= a;
      b = b >> 1;
      a = a << 1;
      if (a & 256) a ^= 'h11B;
    end
    return r & 255;
  endfunction

  function automatic logic [7:0] refSbox(input int x);
    int inv = 0;
    logic [7:0] b, o;
    for (int c = 1; c < 256; c++)
      if (x != 0 && aesMul(x, c) == 1) inv = c;
    b = 8'(inv);
    for (int i = 0; i < 8; i++)
      o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ ((8'h63 >> i) & 1);
    return o;
  endfunction

  task automatic checkByte(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: subOut actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic checkFlag(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: errFlag actual %0b expected %0b", req, act, exp);
    end
  endtask

  // drive away from the edge, sample one edge later
  task automatic apply(input logic [7:0] d, input logic [MW-1:0] m);
    @(negedge clk);
    dataIn = d;
    faultMask = m;
    @(posedge clk);
    #1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  logic [7:0] sbRef [256];

  initial begin
    for (int i = 0; i < 256; i++) sbRef[i] = refSbox(i);

    // R1: reset state
    repeat (3) @(negedge clk);
    checkByte("R1", subOut, 8'h00);
    checkFlag("R1", errFlag, 1'b0);
    rstN = 1'b1;
    #1;
    checkByte("R1", subOut, 8'h00);

    // R3: zero input
    apply(8'h00, '0);
    checkByte("R3", subOut, 8'h63);
    checkFlag("R3", errFlag, 1'b0);

    // R6: output does not move before the edge
    @(negedge clk);
    dataIn = 8'h53;
    #1;
    checkByte("R6", subOut, 8'h63);
    @(posedge clk);
    #1;
    checkByte("R6", subOut, 8'hED);

    // R2, R4: fault-free sweep of all inputs
    for (int i = 0; i < 256; i++) begin
      apply(8'(i), '0);
      checkByte("R2", subOut, sbRef[i]);
      checkFlag("R4", errFlag, 1'b0);
    end

    // R5, R7: every single-bit fault at every input
    for (int i = 0; i < 256; i++) begin
      for (int k = 0; k < MW; k++) begin
        apply(8'(i), MW'(1) << k);
        checkFlag("R5", errFlag, 1'b1);
        if (k >= 40) checkByte("R7", subOut, sbRef[i] ^ (8'd1 << (k - 40)));
      end
    end

    // R8: faults in two different stages at once
    apply(8'hA7, (MW'(1) << 2) | (MW'(1) << 25));
    checkFlag("R8", errFlag, 1'b1);
    apply(8'h01, (MW'(1) << 14) | (MW'(1) << 45));
    checkFlag("R8", errFlag, 1'b1);
    checkByte("R8", subOut === sbRef[1] ? 8'h00 : 8'h01, 8'h01);

    // back to fault-free, flag must drop
    apply(8'hFF, '0);
    checkByte("R2", subOut, sbRef[255]);
    checkFlag("R4", errFlag, 1'b0);

    finish();
  end

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish();
  end

endmodule